// File: doc/BRIEF.md
# Serial Flash Programming Command Port

This block is the device-side end of a serial programming link for a small on-chip flash array. A host moves 8-bit transfers over a serial clock line and a data line. The block decodes two operations. The first is a timed erase, which fills the whole array with 0xFF while a busy output stays high. The second is an erase-verify read, which takes a 16-bit address and captures the addressed byte when an active-low output-enable pulse arrives. It then returns that byte on the data line. The shared data line is modelled as a separate input, a separate output and an output-enable. Any other command code is ignored.

The serial clock idles high. Each bit is a falling edge followed by a rising edge. The block samples incoming bits on the rising edge and drives outgoing bits on the falling edge. The serial clock, data and output-enable inputs are brought into the system clock domain through two-flop synchronisers, and all edges are detected there. The erase time is a whole number of system clock cycles, taken from the clock frequency parameter. The array is a register file of `DEPTH` bytes (a power of two). Reset loads each location with a known pattern, which stands in for contents that were programmed earlier.

Top module: `sfp_port`

## Requirements
- R1: During reset and straight after it, `busy` and `sda_oe` are both 0.
- R2: An erase starts only after command code 0x20 arrives in two consecutive transfers. `busy` rises within a few system clocks of the 8th serial clock rise of the second transfer. After a single 0x20 transfer, `busy` stays 0.
- R3: `busy` stays high for exactly ERASE_CYCLES = CLK_KHZ*19/2 system clock cycles (9.5 ms) and then returns to 0.
- R4: After an erase, every array location reads 0xFF.
- R5: If a 0x20 transfer is followed by any other code, the pending erase is dropped: `busy` stays 0, no location changes, and the next transfer is decoded as a new command.
- R6: Erase verify is code 0xA0, then the low address byte, then the high address byte. Every received byte is sampled on rising serial clock edges, least significant bit first. The location read is the address modulo DEPTH.
- R7: While `oe_n` is low, the addressed byte is captured. Once `oe_n` has returned high, the first falling serial clock edge sets `sda_oe` to 1 and drives D0 on `sda_out`. Each later falling edge drives the next bit, ending with D7.
- R8: `sda_oe` returns to 0 after the 8th rising serial clock edge of the output transfer, and the decoder returns to idle.
- R9: Serial clock activity and `oe_n` pulses while `busy` is 1 are ignored. `sda_oe` stays 0, and after `busy` falls the next transfer is decoded as a fresh command.
- R10: Reset loads location i with the byte (i mod 256) XOR 0xA5.
- R11: A first transfer carrying a code other than 0x20 or 0xA0 leaves the decoder idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idles high |
| sda_in | input | 1 | Serial data from the host |
| oe_n | input | 1 | Active-low output-enable; its low pulse captures verify data |
| sda_out | output | 1 | Serial data to the host |
| sda_oe | output | 1 | High while the block drives the data line |
| busy | output | 1 | High while an erase is running |

## Verification
On every cycle, the assertions check the following: `busy` rises only on a byte boundary, `busy` stays up while the erase timer runs, the array holds 0xFF right after the erase pulse, the data line starts driving only after a falling serial edge, the line is released after the last rising edge, and the line is never driven during an erase. Only the bench scenarios can show the rest. These are the exact erase length, the least-significant-bit-first address and data order, the address wrap modulo the depth, the discarded half-erase, unknown codes, and the decoder coming out of an erase cleanly aligned despite traffic during it.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_VERIFY = 8'hA0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERA1,
    ST_ADRL,
    ST_ADRH,
    ST_WAIT,
    ST_SHOUT,
    ST_ERASE
  } sfp_state_e;

  // contents loaded at reset in place of earlier programming
  function automatic logic [7:0] seed_byte(input int unsigned idx);
    return 8'(idx) ^ 8'hA5;
  endfunction

endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end

endmodule

// File: rtl/sfp_shifter.sv
module sfp_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_s,
  input  logic       sda_s,
  input  logic       count_en,
  input  logic       tx_en,
  input  logic       tx_load,
  input  logic [7:0] tx_data,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       sda_out,
  output logic       sda_oe
);

  logic       sclk_q;
  logic [2:0] cnt_q, cnt_d;
  logic [7:0] rx_q, rx_d;
  logic [7:0] tx_q, tx_d;
  logic       out_q, out_d;
  logic       oe_q, oe_d;
  logic       rise, fall;

  assign rise      = sclk_s & ~sclk_q;
  assign fall      = ~sclk_s & sclk_q;
  assign byte_done = count_en & rise & (cnt_q == 3'd7);
  assign rx_byte   = {sda_s, rx_q[7:1]};

  always_comb begin
    cnt_d = cnt_q;
    rx_d  = rx_q;
    tx_d  = tx_q;
    out_d = out_q;
    oe_d  = oe_q;
    if (count_en && rise) begin
      cnt_d = cnt_q + 3'd1;
      rx_d  = rx_byte;
    end
    if (tx_load) begin
      tx_d = tx_data;
    end else if (tx_en && fall) begin
      tx_d  = {1'b0, tx_q[7:1]};
      out_d = tx_q[0];
    end
    if (!tx_en || byte_done) oe_d = 1'b0;
    else if (fall)           oe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      out_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      out_q  <= out_d;
      oe_q   <= oe_d;
    end
  end

  assign sda_out = out_q;
  assign sda_oe  = oe_q;

  // R7: the line is taken only after a falling serial edge
  a_r7_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(fall));

  // R8: the line is released after the last rising edge
  a_r8_release_last: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && byte_done) |=> !oe_q);

endmodule

// File: rtl/sfp_array.sv
module sfp_array import sfp_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase_all,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_data
);

  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [7:0] word_d;
    assign word_d = erase_all ? 8'hFF : mem_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= seed_byte(g);
      else        mem_q[g] <= word_d;
    end
  end

  assign rd_data = mem_q[rd_idx];

  // R4: an erase pulse leaves the first and last location at 0xFF
  a_r4_erase_fill: assert property (@(posedge clk) disable iff (!rst_n)
    erase_all |=> (mem_q[0] == 8'hFF && mem_q[DEPTH-1] == 8'hFF));

endmodule

// File: rtl/sfp_ctrl.sv
module sfp_ctrl import sfp_pkg::*; #(
  parameter int AW           = 4,
  parameter int ERASE_CYCLES = 950
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_done,
  input  logic [7:0]    rx_byte,
  input  logic          oe_n_s,
  output logic          count_en,
  output logic          tx_en,
  output logic          latch_en,
  output logic          erase_all,
  output logic [AW-1:0] rd_idx,
  output logic          busy
);

  localparam int TW = $clog2(ERASE_CYCLES + 1);

  sfp_state_e    state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [7:0]    lo_q, lo_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          has_q, has_d;

  always_comb begin
    state_d   = state_q;
    tmr_d     = tmr_q;
    lo_d      = lo_q;
    idx_d     = idx_q;
    has_d     = has_q;
    latch_en  = 1'b0;
    erase_all = 1'b0;
    unique case (state_q)
      ST_IDLE: if (byte_done) begin
        if (rx_byte == CMD_ERASE)       state_d = ST_ERA1;
        else if (rx_byte == CMD_VERIFY) state_d = ST_ADRL;
      end
      ST_ERA1: if (byte_done) begin
        if (rx_byte == CMD_ERASE) begin
          state_d   = ST_ERASE;
          tmr_d     = TW'(ERASE_CYCLES - 1);
          erase_all = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_ADRL: if (byte_done) begin
        lo_d    = rx_byte;
        state_d = ST_ADRH;
      end
      ST_ADRH: if (byte_done) begin
        idx_d   = AW'({rx_byte, lo_q});
        has_d   = 1'b0;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!oe_n_s) begin
          latch_en = 1'b1;
          has_d    = 1'b1;
        end else if (has_q) begin
          state_d = ST_SHOUT;
        end
      end
      ST_SHOUT: if (byte_done) state_d = ST_IDLE;
      ST_ERASE: begin
        if (tmr_q == '0) state_d = ST_IDLE;
        else             tmr_d   = tmr_q - TW'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      lo_q    <= '0;
      idx_q   <= '0;
      has_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      lo_q    <= lo_d;
      idx_q   <= idx_d;
      has_q   <= has_d;
    end
  end

  assign busy     = (state_q == ST_ERASE);
  assign tx_en    = (state_q == ST_SHOUT);
  assign count_en = (state_q != ST_ERASE) && (state_q != ST_WAIT);
  assign rd_idx   = idx_q;

  // R2: an erase begins only on a byte boundary
  a_r2_start_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(byte_done));

  // R3: busy holds while the timer has cycles left
  a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmr_q != '0) |=> busy);

endmodule

// File: rtl/sfp_port.sv
module sfp_port #(
  parameter int DEPTH   = 16,
  parameter int CLK_KHZ = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sda_in,
  input  logic oe_n,
  output logic sda_out,
  output logic sda_oe,
  output logic busy
);

  localparam int AW           = $clog2(DEPTH);
  localparam int ERASE_CYCLES = CLK_KHZ * 19 / 2;

  logic          rst_m_q, rst_i_n;
  logic [2:0]    pins_s;
  logic          byte_done, count_en, tx_en, latch_en, erase_all;
  logic [7:0]    rx_byte, rd_data;
  logic [AW-1:0] rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_i_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_i_n <= rst_m_q;
    end
  end

  sfp_sync #(.W(3), .RST_VAL(3'b101)) sync_i (
    .clk(clk), .rst_n(rst_i_n),
    .async_i({sclk, sda_in, oe_n}), .sync_o(pins_s)
  );

  sfp_shifter shift_i (
    .clk(clk), .rst_n(rst_i_n),
    .sclk_s(pins_s[2]), .sda_s(pins_s[1]),
    .count_en(count_en), .tx_en(tx_en),
    .tx_load(latch_en), .tx_data(rd_data),
    .byte_done(byte_done), .rx_byte(rx_byte),
    .sda_out(sda_out), .sda_oe(sda_oe)
  );

  sfp_ctrl #(.AW(AW), .ERASE_CYCLES(ERASE_CYCLES)) ctrl_i (
    .clk(clk), .rst_n(rst_i_n),
    .byte_done(byte_done), .rx_byte(rx_byte), .oe_n_s(pins_s[0]),
    .count_en(count_en), .tx_en(tx_en), .latch_en(latch_en),
    .erase_all(erase_all), .rd_idx(rd_idx), .busy(busy)
  );

  sfp_array #(.DEPTH(DEPTH)) array_i (
    .clk(clk), .rst_n(rst_i_n),
    .erase_all(erase_all), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // R9: the data line is never driven during an erase
  a_r9_quiet_busy: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy |-> !sda_oe);

  // R1: outputs idle while reset is held
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_i_n |-> (!busy && !sda_oe));

endmodule

// File: tb/sfp_port_tb_top.sv
module sfp_port_tb_top;

  localparam int DEPTH   = 16;
  localparam int CLK_KHZ = 100;
  localparam int ERASE_N = CLK_KHZ * 19 / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic sda_in = 1'b0;
  logic oe_n = 1'b1;
  logic sda_out, sda_oe, busy;

  int n_chk = 0;
  int n_fail = 0;
  int busy_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sfp_port #(.DEPTH(DEPTH), .CLK_KHZ(CLK_KHZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sda_in(sda_in), .oe_n(oe_n),
    .sda_out(sda_out), .sda_oe(sda_oe), .busy(busy)
  );

  always @(negedge clk) if (busy) busy_cnt <= busy_cnt + 1;

  // {address, expected byte}; expected = (address mod 16) ^ 0xA5
  localparam logic [23:0] VEC [6] = '{
    {16'h0000, 8'hA5}, {16'h0003, 8'hA6}, {16'h000F, 8'hAA},
    {16'h0010, 8'hA5}, {16'hFFFF, 8'hAA}, {16'h1234, 8'hA1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0;
      sda_in = b[i];
      wait_clk(6);
      sclk = 1'b1;
      wait_clk(6);
    end
  endtask

  task automatic read_byte(output logic [7:0] d, output logic oe_ok, output logic rel_ok);
    oe_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0;
      wait_clk(6);
      d[i] = sda_out;
      if (sda_oe !== 1'b1) oe_ok = 1'b0;
      sclk = 1'b1;
      wait_clk(6);
    end
    rel_ok = (sda_oe === 1'b0);
  endtask

  task automatic verify(input logic [15:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    logic oe_ok, rel_ok;
    send_byte(8'hA0);
    send_byte(a[7:0]);
    send_byte(a[15:8]);
    oe_n = 1'b0;
    wait_clk(6);
    oe_n = 1'b1;
    wait_clk(6);
    read_byte(d, oe_ok, rel_ok);
    chk({tag, " data"}, {24'h0, d}, {24'h0, exp});
    chk("R7 drive during output", {31'h0, oe_ok}, 32'h1);
    chk("R8 release after 8th rise", {31'h0, rel_ok}, 32'h1);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    wait_clk(3);
    chk("R1 busy in reset", {31'h0, busy}, 32'h0);
    chk("R1 sda_oe in reset", {31'h0, sda_oe}, 32'h0);
    rst_n = 1'b1;
    wait_clk(6);
    chk("R1 busy after reset", {31'h0, busy}, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int b0, b1;
    do_reset();

    // R6 R7 R10: table of verify reads on reset contents, address wraps mod DEPTH
    foreach (VEC[k]) verify(VEC[k][23:8], VEC[k][7:0], "R6 R10 table read");

    // R11: unknown code leaves decoder idle
    send_byte(8'h55);
    chk("R11 busy after unknown code", {31'h0, busy}, 32'h0);
    verify(16'h0002, 8'hA7, "R11 read after unknown code");

    // R5: 0x20 then another code discards the erase
    send_byte(8'h20);
    send_byte(8'h33);
    wait_clk(6);
    chk("R5 no busy after 20,33", {31'h0, busy}, 32'h0);
    verify(16'h0005, 8'hA0, "R5 contents kept");

    // R2 R3: erase
    send_byte(8'h20);
    chk("R2 one 0x20 not enough", {31'h0, busy}, 32'h0);
    b0 = busy_cnt;
    send_byte(8'h20);
    chk("R2 busy after second 0x20", {31'h0, busy}, 32'h1);
    for (int t = 0; t < 4 * ERASE_N && busy; t++) wait_clk(1);
    wait_clk(2);
    b1 = busy_cnt;
    chk("R3 busy length", b1 - b0, ERASE_N);
    chk("R3 busy low after erase", {31'h0, busy}, 32'h0);

    // R4: every location erased
    for (int a = 0; a < DEPTH; a++) verify(16'(a), 8'hFF, "R4 erased location");

    // R1 R10: reset restores pattern
    do_reset();
    verify(16'h0006, 8'hA3, "R10 pattern after reset");

    // R9: traffic during busy ignored
    send_byte(8'h20);
    send_byte(8'h20);
    chk("R9 busy started", {31'h0, busy}, 32'h1);
    send_byte(8'hA0);
    send_byte(8'h07);
    send_byte(8'h00);
    oe_n = 1'b0;
    wait_clk(6);
    oe_n = 1'b1;
    wait_clk(6);
    chk("R9 line quiet during busy", {31'h0, sda_oe}, 32'h0);
    chk("R9 still busy", {31'h0, busy}, 32'h1);
    for (int t = 0; t < 4 * ERASE_N && busy; t++) wait_clk(1);
    wait_clk(2);
    verify(16'h0009, 8'hFF, "R9 fresh command after busy");

    finish_run();
  end

endmodule